// File: doc/BRIEF.md
# Multi-CPU Interrupt Acknowledge Arbiter

This block sits between a set of shared, level-sensitive peripheral interrupt lines and several CPUs. Each line has a programmable affinity mask that picks which CPUs may take it. Every CPU has its own interface with the same layout: an IRQ output, an acknowledge read strobe that returns an interrupt ID, and an end-of-interrupt write.

The acknowledge read is what claims an interrupt. When CPUs read in the same cycle, the lower CPU index is served first, and each reader receives a different ID. A CPU that finds nothing left for it receives the spurious ID, which is the all-ones value of the ID field (1023 with the 10-bit field). A claimed interrupt becomes active and stays hidden from all CPUs until the CPU that claimed it writes that ID to its end-of-interrupt port. If the line is still high at that point, the interrupt is offered again.

Top module: `irq_ack_arbiter`

## Requirements
- R1: While reset is held, and on the first cycle after it, every irq_o bit and every ack_vld_o bit is 0, and all affinity masks are 0.
- R2: irq_o[c] is 1 exactly when at least one line i is high, is not active, and has bit c set in its affinity mask. It is combinational from the current state.
- R3: A high ack_rd_i[c] at a clock edge sets ack_vld_o[c] for the following cycle. ack_id_o[c*10 +: 10] then holds the lowest-numbered interrupt that is eligible for CPU c and has not been taken by a lower-indexed CPU in that edge.
- R4: When several CPUs read at the same edge, they are served in ascending CPU index. No two readers receive the same non-spurious ID, and CPU 0 receives an ID whenever its irq_o was high.
- R5: A reader that has no eligible interrupt left receives the spurious ID 1023.
- R6: An acknowledged interrupt is active from the next cycle. It does not drive any irq_o, and no acknowledge returns it until it is ended.
- R7: An end-of-interrupt write (eoi_we_i[c] together with the ID on eoi_id_i[c*10 +: 10]) clears the active state only when CPU c is the one that acknowledged that ID. Writes from any other CPU, and writes for an ID that is not active, have no effect.
- R8: cfg_we_i writes cfg_mask_i (bit c selects CPU c) into the affinity mask of interrupt cfg_idx_i. A CPU whose bit is clear never sees that interrupt on irq_o and never receives it on acknowledge.
- R9: After a valid end-of-interrupt, an interrupt whose line is still high is offered again. One whose line is low is not offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_lines_i | input | N_IRQ | Level-sensitive shared interrupt lines |
| cfg_we_i | input | 1 | Affinity mask write strobe |
| cfg_idx_i | input | IDX_W | Interrupt selected by the affinity write |
| cfg_mask_i | input | N_CPU | Affinity mask, one bit per CPU |
| ack_rd_i | input | N_CPU | Acknowledge read strobe, one bit per CPU |
| ack_vld_o | output | N_CPU | Acknowledge result valid, one cycle after the read |
| ack_id_o | output | N_CPU*10 | Acknowledged ID for each CPU, packed by CPU index |
| eoi_we_i | input | N_CPU | End-of-interrupt write strobe, one bit per CPU |
| eoi_id_i | input | N_CPU*10 | End-of-interrupt ID for each CPU, packed by CPU index |
| irq_o | output | N_CPU | Per-CPU interrupt request |

## Verification
A single CPU reading with no lines raised shows that the spurious path works on its own. Two, and then all four, CPUs reading in the same cycle over overlapping affinity masks separate the ordering by CPU index and the exclusion of already-taken IDs from a simple lowest-ID pick. End-of-interrupt writes from the wrong CPU, and then from the owner with the line held high or dropped, separate ownership tracking from a plain clear. A long pseudo-random run of line levels, read masks and end-of-interrupt writes, checked against a reference model, exposes any ordering or state slip that the directed cases miss.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int ID_W = 10;
  typedef logic [ID_W-1:0] irq_id_t;
  localparam irq_id_t SPUR_ID = '1;
endpackage

// File: rtl/irq_aff_regs.sv
module irq_aff_regs #(
  parameter int N_CPU = 4,
  parameter int N_IRQ = 16,
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [N_CPU-1:0]            mask_i,
  output logic [N_IRQ-1:0][N_CPU-1:0] aff_o
);
  for (genvar i = 0; i < N_IRQ; i++) begin : g_aff
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                aff_o[i] <= '0;
      else if (we_i && (idx_i == IDX_W'(i)))      aff_o[i] <= mask_i;
    end
  end
endmodule

// File: rtl/irq_ffs.sv
module irq_ffs
  import irq_arb_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] vec_i,
  output logic [W-1:0] onehot_o,
  output logic         found_o,
  output irq_id_t      idx_o
);
  assign onehot_o = vec_i & (~vec_i + W'(1));
  assign found_o  = |vec_i;

  always_comb begin
    idx_o = SPUR_ID;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = ID_W'(i);
    end
  end
endmodule

// File: rtl/irq_pick_chain.sv
module irq_pick_chain
  import irq_arb_pkg::*;
#(
  parameter int N_CPU = 4,
  parameter int N_IRQ = 16
) (
  input  logic [N_CPU-1:0][N_IRQ-1:0] cand_i,
  input  logic [N_CPU-1:0]            rd_i,
  output logic [N_CPU-1:0][N_IRQ-1:0] gnt_o,
  output irq_id_t [N_CPU-1:0]         id_o
);
  // avail[c]: interrupts not yet taken by CPUs below c in this cycle
  logic [N_IRQ-1:0] avail [N_CPU+1];
  assign avail[0] = '1;

  for (genvar c = 0; c < N_CPU; c++) begin : g_stage
    logic [N_IRQ-1:0] sel, first;
    logic             found;
    irq_id_t          idx;

    assign sel = cand_i[c] & avail[c];

    irq_ffs #(.W(N_IRQ)) ffs_i (
      .vec_i    (sel),
      .onehot_o (first),
      .found_o  (found),
      .idx_o    (idx)
    );

    assign gnt_o[c]     = rd_i[c] ? first : '0;
    assign id_o[c]      = found ? idx : SPUR_ID;
    assign avail[c+1]   = avail[c] & ~gnt_o[c];
  end
endmodule

// File: rtl/irq_ack_arbiter.sv
module irq_ack_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_CPU = 4,
  parameter int N_IRQ = 16,
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
  localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_IRQ-1:0]      irq_lines_i,
  input  logic                  cfg_we_i,
  input  logic [IDX_W-1:0]      cfg_idx_i,
  input  logic [N_CPU-1:0]      cfg_mask_i,
  input  logic [N_CPU-1:0]      ack_rd_i,
  output logic [N_CPU-1:0]      ack_vld_o,
  output logic [N_CPU*ID_W-1:0] ack_id_o,
  input  logic [N_CPU-1:0]      eoi_we_i,
  input  logic [N_CPU*ID_W-1:0] eoi_id_i,
  output logic [N_CPU-1:0]      irq_o
);
  logic [N_IRQ-1:0][N_CPU-1:0] aff;
  logic [N_CPU-1:0][N_IRQ-1:0] cand, gnt;
  irq_id_t [N_CPU-1:0]         pick_id;
  logic [N_IRQ-1:0]            act_q, elig, set_act, clr_act;
  logic [CPU_W-1:0]            own_q [N_IRQ];
  irq_id_t [N_CPU-1:0]         ack_id_q;

  irq_aff_regs #(.N_CPU(N_CPU), .N_IRQ(N_IRQ)) aff_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .idx_i  (cfg_idx_i),
    .mask_i (cfg_mask_i),
    .aff_o  (aff)
  );

  assign elig = irq_lines_i & ~act_q;

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    for (genvar i = 0; i < N_IRQ; i++) begin : g_route
      assign cand[c][i] = elig[i] & aff[i][c];
    end
    assign irq_o[c] = |cand[c];
    assign ack_id_o[c*ID_W +: ID_W] = ack_id_q[c];
  end

  irq_pick_chain #(.N_CPU(N_CPU), .N_IRQ(N_IRQ)) pick_i (
    .cand_i (cand),
    .rd_i   (ack_rd_i),
    .gnt_o  (gnt),
    .id_o   (pick_id)
  );

  // only the owning CPU may end an active interrupt
  always_comb begin
    set_act = '0;
    clr_act = '0;
    for (int c = 0; c < N_CPU; c++) begin
      set_act |= gnt[c];
      for (int i = 0; i < N_IRQ; i++) begin
        if (eoi_we_i[c] && act_q[i] && (own_q[i] == CPU_W'(c)) &&
            (eoi_id_i[c*ID_W +: ID_W] == ID_W'(i)))
          clr_act[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= (act_q & ~clr_act) | set_act;
  end

  for (genvar i = 0; i < N_IRQ; i++) begin : g_own
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        own_q[i] <= '0;
      end else begin
        for (int c = 0; c < N_CPU; c++) begin
          if (gnt[c][i]) own_q[i] <= CPU_W'(c);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_vld_o <= '0;
      ack_id_q  <= {N_CPU{SPUR_ID}};
    end else begin
      ack_vld_o <= ack_rd_i;
      for (int c = 0; c < N_CPU; c++) begin
        if (ack_rd_i[c]) ack_id_q[c] <= pick_id[c];
      end
    end
  end
endmodule

// File: rtl/irq_ack_arbiter_chk.sv
module irq_ack_arbiter_chk
  import irq_arb_pkg::*;
#(
  parameter int N_CPU = 4,
  parameter int N_IRQ = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [N_IRQ-1:0]      irq_lines_i,
  input logic [N_CPU-1:0]      ack_rd_i,
  input logic [N_CPU-1:0]      ack_vld_o,
  input logic [N_CPU*ID_W-1:0] ack_id_o,
  input logic [N_CPU-1:0]      irq_o
);
  AST_NO_LINE_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_lines_i == '0) |-> (irq_o == '0)); // R2

  AST_CPU0_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd_i[0] && irq_o[0]) |=> (ack_id_o[0 +: ID_W] != SPUR_ID)); // R4

  for (genvar c = 0; c < N_CPU; c++) begin : g_c
    AST_VLD_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_rd_i[c] |=> ack_vld_o[c]); // R3

    AST_ID_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_vld_o[c] && (ack_id_o[c*ID_W +: ID_W] != SPUR_ID)) |->
      (ack_id_o[c*ID_W +: ID_W] < ID_W'(N_IRQ))); // R3

    AST_SPUR_IF_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_rd_i[c] && !irq_o[c]) |=> (ack_id_o[c*ID_W +: ID_W] == SPUR_ID)); // R5

    for (genvar d = c + 1; d < N_CPU; d++) begin : g_d
      AST_DISTINCT_IDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_vld_o[c] && ack_vld_o[d] && (ack_id_o[c*ID_W +: ID_W] != SPUR_ID)) |->
        (ack_id_o[c*ID_W +: ID_W] != ack_id_o[d*ID_W +: ID_W])); // R4
    end
  end
endmodule

bind irq_ack_arbiter irq_ack_arbiter_chk #(.N_CPU(N_CPU), .N_IRQ(N_IRQ)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_lines_i (irq_lines_i),
  .ack_rd_i    (ack_rd_i),
  .ack_vld_o   (ack_vld_o),
  .ack_id_o    (ack_id_o),
  .irq_o       (irq_o)
);

// File: tb/irq_ack_arbiter_tb_top.sv
module irq_ack_arbiter_tb_top;
  localparam int N_CPU = 4;
  localparam int N_IRQ = 16;
  localparam int ID_W  = 10;
  localparam int SPUR  = 1023;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [N_IRQ-1:0]      irq_lines_i = '0;
  logic                  cfg_we_i = 1'b0;
  logic [3:0]            cfg_idx_i = '0;
  logic [N_CPU-1:0]      cfg_mask_i = '0;
  logic [N_CPU-1:0]      ack_rd_i = '0;
  logic [N_CPU-1:0]      ack_vld_o;
  logic [N_CPU*ID_W-1:0] ack_id_o;
  logic [N_CPU-1:0]      eoi_we_i = '0;
  logic [N_CPU*ID_W-1:0] eoi_id_i = '0;
  logic [N_CPU-1:0]      irq_o;

  always #4 clk_i = ~clk_i;

  irq_ack_arbiter #(.N_CPU(N_CPU), .N_IRQ(N_IRQ)) dut_i (.*);

  typedef struct { int cpu; int id; string tag; } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int errors = 0;

  logic [N_CPU-1:0] m_aff [N_IRQ];
  logic             m_act [N_IRQ];
  int               m_own [N_IRQ];

  // monitor: pops one expected item per valid acknowledge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      for (int c = 0; c < N_CPU; c++) begin
        if (ack_vld_o[c]) begin
          int got;
          got = int'(ack_id_o[c*ID_W +: ID_W]);
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R3: cpu%0d unexpected ack actual=%0d expected=none", c, got);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.cpu != c || e.id != got) begin
              errors++;
              $display("FAIL %s: ack cpu%0d id actual=%0d expected cpu%0d id %0d",
                       e.tag, c, got, e.cpu, e.id);
            end
          end
        end
      end
    end
  end

  task automatic check_irq(string tag);
    logic [N_CPU-1:0] exp_irq;
    #1;
    exp_irq = '0;
    for (int i = 0; i < N_IRQ; i++)
      if (irq_lines_i[i] && !m_act[i]) exp_irq |= m_aff[i];
    checks++;
    if (irq_o !== exp_irq) begin
      errors++;
      $display("FAIL %s: irq_o actual=%b expected=%b", tag, irq_o, exp_irq);
    end
  endtask

  task automatic set_aff(int idx, logic [N_CPU-1:0] m);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = 4'(idx); cfg_mask_i = m;
    m_aff[idx] = m;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic do_ack(logic [N_CPU-1:0] rd, string tag);
    logic taken [N_IRQ];
    @(negedge clk_i);
    for (int i = 0; i < N_IRQ; i++) taken[i] = 1'b0;
    for (int c = 0; c < N_CPU; c++) begin
      if (rd[c]) begin
        exp_t e;
        e.cpu = c; e.id = SPUR; e.tag = tag;
        for (int i = 0; i < N_IRQ; i++) begin
          if (e.id == SPUR && irq_lines_i[i] && !m_act[i] && !taken[i] && m_aff[i][c])
            e.id = i;
        end
        if (e.id != SPUR) taken[e.id] = 1'b1;
        exp_q.push_back(e);
      end
    end
    for (int i = 0; i < N_IRQ; i++)
      if (taken[i]) begin
        m_act[i] = 1'b1;
        for (int c = N_CPU - 1; c >= 0; c--) if (rd[c]) m_own[i] = c;
      end
    // owner: recompute in order to match the CPU that actually took it
    begin
      logic tk2 [N_IRQ];
      for (int i = 0; i < N_IRQ; i++) tk2[i] = 1'b0;
      foreach (exp_q[k]) if (exp_q[k].id != SPUR && !tk2[exp_q[k].id]) begin
        tk2[exp_q[k].id] = 1'b1;
        m_own[exp_q[k].id] = exp_q[k].cpu;
      end
    end
    ack_rd_i = rd;
    @(negedge clk_i);
    ack_rd_i = '0;
  endtask

  task automatic do_eoi(int c, int id);
    @(negedge clk_i);
    eoi_we_i = '0;
    eoi_we_i[c] = 1'b1;
    eoi_id_i[c*ID_W +: ID_W] = ID_W'(id);
    if (id < N_IRQ && m_act[id] && m_own[id] == c) m_act[id] = 1'b0;
    @(negedge clk_i);
    eoi_we_i = '0;
  endtask

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < N_IRQ; i++) begin
      m_aff[i] = '0; m_act[i] = 1'b0; m_own[i] = 0;
    end
    repeat (3) @(negedge clk_i);
    // R1: reset state
    checks++;
    if (irq_o !== '0 || ack_vld_o !== '0) begin
      errors++;
      $display("FAIL R1: in reset irq_o=%b ack_vld_o=%b expected 0 0", irq_o, ack_vld_o);
    end
    rst_ni = 1'b1;
    irq_lines_i = '1;
    check_irq("R1");
    irq_lines_i = '0;

    set_aff(3, 4'b0001);
    set_aff(5, 4'b0011);
    set_aff(7, 4'b1111);
    set_aff(9, 4'b0100);
    set_aff(12, 4'b0010);
    check_irq("R2");
    do_ack(4'b0001, "R5");

    @(negedge clk_i);
    irq_lines_i = 16'h12A8;
    check_irq("R2");
    do_ack(4'b0011, "R4");
    do_ack(4'b1111, "R4");
    check_irq("R6");
    do_ack(4'b0001, "R6");

    do_eoi(1, 3);
    check_irq("R7");
    do_ack(4'b0001, "R7");
    do_eoi(0, 6);
    check_irq("R7");

    do_eoi(0, 3);
    check_irq("R9");
    do_ack(4'b0001, "R9");

    @(negedge clk_i);
    irq_lines_i[5] = 1'b0;
    do_eoi(1, 5);
    check_irq("R9");
    do_ack(4'b0011, "R9");

    do_eoi(2, 9);
    check_irq("R8");
    do_ack(4'b1000, "R8");
    do_ack(4'b0100, "R8");

    // pseudo-random soak against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < N_IRQ; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      set_aff(i, (lfsr[3:0] == 4'b0) ? 4'b0001 : lfsr[3:0]);
    end
    for (int it = 0; it < 60; it++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(negedge clk_i);
      irq_lines_i = lfsr ^ {lfsr[7:0], lfsr[15:8]};
      check_irq("R2");
      do_ack(lfsr[11:8], "R3");
      check_irq("R6");
      for (int k = 0; k < 2; k++) begin
        int id;
        id = (int'(lfsr[15:12]) + k * 7) % N_IRQ;
        do_eoi((it % 3 == 0) ? (m_own[id] + 1) % N_CPU : m_own[id], id);
      end
      check_irq("R7");
    end

    repeat (2) @(negedge clk_i);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3: missing acks actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule